// File: doc/BRIEF.md
# Interleaved Transmit Pattern Engine

This block feeds a bank of time-interleaved current-steering DAC lanes from a software-loaded pattern store. Every clock it reads one row of the store. A row holds one code per lane. Each code is added to a signed correction drawn from a small table. The table is indexed by the symbol's position inside a fixed noise period, so a constant offset minus the measured coupling at each position can be cancelled. The corrected code is clamped to the code range. It is then split into a unary section for the upper bits and a binary section for the lower bits, which is the form the segmented current-source array consumes.

While `run_en` is high the row pointer steps through the store and loops after the programmed last row, so a precompensated or equalized sequence repeats with no gaps. The correction position steps by the lane count each cycle and wraps at the period length. Dropping `run_en` rewinds both the row pointer and the position to zero. The next run therefore starts from row 0, position 0. The lane outputs are registered. Their data flow has no back-pressure: the DAC consumes one symbol group every cycle. `lane_vld` only marks which output cycles carry a fresh group, and there is no ready input. The two write ports are plain strobes that take effect at the clock edge.

Top module: `tpe_tx_engine`

## Requirements
- R1: After reset `lane_vld` is 0 and every bit of `lane_therm` and `lane_bin` is 0. All correction entries are 0.
- R2: A row read while `run_en` is high in cycle t appears on the outputs in cycle t+2, with `lane_vld` high. Lane k takes its code from bits [8k+7:8k] of the row as it was written on `pat_wdata`.
- R3: The code plus its correction is clamped before splitting. A sum above 255 is output as 255 (unary all ones, binary 31). A sum below 0 is output as 0 (all zeros).
- R4: For a clamped code c, lane k's unary field `lane_therm[7k+6:7k]` holds exactly c[7:5] ones in its low-order bits. Its binary field `lane_bin[5k+4:5k]` equals c[4:0].
- R5: Corrections are 8-bit two's complement values. The position base is 0 in the first enabled cycle of a run and grows by 8 modulo 32 in each further enabled cycle. Lane k uses the entry at index (base + k) mod 32, as written through `cor_idx`/`cor_wdata`.
- R6: The row pointer is 0 in the first enabled cycle of a run. It steps by one each enabled cycle and returns to 0 after the row equal to `seq_last`, so `seq_last` = 0 repeats row 0.
- R7: When `run_en` is low, `lane_vld` is low two cycles later, and the lane outputs keep the last group they presented. Pointer and position are rewound so that the next run restarts at row 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Stream the pattern while high; rewind while low |
| seq_last | input | 4 | Index of the final row of the looping sequence |
| pat_we | input | 1 | Pattern store write strobe |
| pat_addr | input | 4 | Pattern store row address |
| pat_wdata | input | 64 | Row data, lane k in bits [8k+7:8k] |
| cor_we | input | 1 | Correction table write strobe |
| cor_idx | input | 5 | Correction table position (0..31) |
| cor_wdata | input | 8 | Signed correction value |
| lane_vld | output | 1 | Lane outputs carry a fresh group this cycle |
| lane_therm | output | 56 | Unary upper sections, 7 bits per lane |
| lane_bin | output | 40 | Binary lower sections, 5 bits per lane |

## Verification
The pointer-step assertions take for granted that `seq_last` stays constant while a run is active and is never below the current row pointer. The stimulus changes `seq_last` only between runs, when `run_en` has been low for at least one edge. The latency and clamping checks also assume that no row or correction entry is rewritten in the cycle it is read, because a write at the read address returns the old value. The bench loads both tables while the engine is stopped, so this case never arises.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int TPE_LANES  = 8;
  localparam int TPE_CODE_W = 8;
  localparam int TPE_MSB_W  = 3;
  localparam int TPE_CORR_W = 8;
  localparam int TPE_PERIOD = 32;
  localparam int TPE_ROWS   = 16;
endpackage

// File: rtl/tpe_pattern_mem.sv
module tpe_pattern_mem #(
  parameter int ROWS  = tpe_pkg::TPE_ROWS,
  parameter int ROW_W = tpe_pkg::TPE_LANES * tpe_pkg::TPE_CODE_W,
  localparam int AW   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ROW_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [ROW_W-1:0] rdata
);
  logic [ROW_W-1:0] store [ROWS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/tpe_corr_table.sv
module tpe_corr_table #(
  parameter int PERIOD = tpe_pkg::TPE_PERIOD,
  parameter int CORR_W = tpe_pkg::TPE_CORR_W,
  parameter int LANES  = tpe_pkg::TPE_LANES,
  localparam int IDX_W = $clog2(PERIOD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        widx,
  input  logic [CORR_W-1:0]       wdata,
  input  logic                    re,
  input  logic [IDX_W-1:0]        base,
  output logic [LANES*CORR_W-1:0] rdata
);
  logic [CORR_W-1:0] tbl [PERIOD];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PERIOD; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[widx] <= wdata;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_port
    logic [IDX_W-1:0] idx;
    assign idx = base + IDX_W'(k);
    always_ff @(posedge clk) begin
      if (!rst_n)  rdata[k*CORR_W +: CORR_W] <= '0;
      else if (re) rdata[k*CORR_W +: CORR_W] <= tbl[idx];
    end
  end
endmodule

// File: rtl/tpe_lane_seg.sv
module tpe_lane_seg #(
  parameter int CODE_W = tpe_pkg::TPE_CODE_W,
  parameter int MSB_W  = tpe_pkg::TPE_MSB_W,
  parameter int CORR_W = tpe_pkg::TPE_CORR_W,
  localparam int TH_W  = (1 << MSB_W) - 1,
  localparam int LSB_W = CODE_W - MSB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [CODE_W-1:0] code,
  input  logic [CORR_W-1:0] corr,
  output logic [TH_W-1:0]   therm,
  output logic [LSB_W-1:0]  bin
);
  localparam int SUM_W = ((CODE_W > CORR_W) ? CODE_W : CORR_W) + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << CODE_W) - 1);

  logic signed [SUM_W-1:0] sum;
  logic [CODE_W-1:0]       clamped;
  logic [MSB_W-1:0]        msb;
  logic [TH_W-1:0]         th_d;

  assign sum = $signed({{(SUM_W-CODE_W){1'b0}}, code})
             + $signed({{(SUM_W-CORR_W){corr[CORR_W-1]}}, corr});

  always_comb begin
    if (sum < 0)         clamped = '0;
    else if (sum > MAXV) clamped = '1;
    else                 clamped = sum[CODE_W-1:0];
  end

  assign msb = clamped[CODE_W-1 -: MSB_W];

  for (genvar i = 0; i < TH_W; i++) begin : g_unary
    assign th_d[i] = (msb > MSB_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      therm <= '0;
      bin   <= '0;
    end else if (vld) begin
      therm <= th_d;
      bin   <= clamped[LSB_W-1:0];
    end
  end

  // R4: unary field is always a run of low-order ones
  p_unary_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((therm & (therm + TH_W'(1))) == '0));
  // R3: overflow clamps to full scale
  p_clamp_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && sum > MAXV) |=> (&therm && &bin));
  // R3: underflow clamps to zero
  p_clamp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && sum < 0) |=> (therm == '0 && bin == '0));
  // R7: outputs hold while no fresh group arrives
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> ($stable(therm) && $stable(bin)));
endmodule

// File: rtl/tpe_tx_engine.sv
module tpe_tx_engine #(
  parameter int LANES  = tpe_pkg::TPE_LANES,
  parameter int CODE_W = tpe_pkg::TPE_CODE_W,
  parameter int MSB_W  = tpe_pkg::TPE_MSB_W,
  parameter int CORR_W = tpe_pkg::TPE_CORR_W,
  parameter int PERIOD = tpe_pkg::TPE_PERIOD,
  parameter int ROWS   = tpe_pkg::TPE_ROWS,
  localparam int AW    = $clog2(ROWS),
  localparam int IDX_W = $clog2(PERIOD),
  localparam int ROW_W = LANES * CODE_W,
  localparam int TH_W  = (1 << MSB_W) - 1,
  localparam int LSB_W = CODE_W - MSB_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run_en,
  input  logic [AW-1:0]          seq_last,
  input  logic                   pat_we,
  input  logic [AW-1:0]          pat_addr,
  input  logic [ROW_W-1:0]       pat_wdata,
  input  logic                   cor_we,
  input  logic [IDX_W-1:0]       cor_idx,
  input  logic [CORR_W-1:0]      cor_wdata,
  output logic                   lane_vld,
  output logic [LANES*TH_W-1:0]  lane_therm,
  output logic [LANES*LSB_W-1:0] lane_bin
);
  logic [AW-1:0]             row_ptr;
  logic [IDX_W-1:0]          pos_base;
  logic                      s1_vld;
  logic [ROW_W-1:0]          row_q;
  logic [LANES*CORR_W-1:0]   cor_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_ptr  <= '0;
      pos_base <= '0;
      s1_vld   <= 1'b0;
      lane_vld <= 1'b0;
    end else begin
      s1_vld   <= run_en;
      lane_vld <= s1_vld;
      if (run_en) begin
        row_ptr  <= (row_ptr == seq_last) ? '0 : row_ptr + AW'(1);
        pos_base <= pos_base + IDX_W'(LANES);
      end else begin
        row_ptr  <= '0;
        pos_base <= '0;
      end
    end
  end

  tpe_pattern_mem #(.ROWS(ROWS), .ROW_W(ROW_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
    .re(run_en), .raddr(row_ptr), .rdata(row_q));

  tpe_corr_table #(.PERIOD(PERIOD), .CORR_W(CORR_W), .LANES(LANES)) u_cor (
    .clk(clk), .rst_n(rst_n), .we(cor_we), .widx(cor_idx), .wdata(cor_wdata),
    .re(run_en), .base(pos_base), .rdata(cor_q));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    tpe_lane_seg #(.CODE_W(CODE_W), .MSB_W(MSB_W), .CORR_W(CORR_W)) u_seg (
      .clk(clk), .rst_n(rst_n), .vld(s1_vld),
      .code(row_q[k*CODE_W +: CODE_W]),
      .corr(cor_q[k*CORR_W +: CORR_W]),
      .therm(lane_therm[k*TH_W +: TH_W]),
      .bin(lane_bin[k*LSB_W +: LSB_W]));
  end

  // R6: pointer returns to row 0 after the last row
  p_ptr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && row_ptr == seq_last) |=> (row_ptr == '0));
  // R6: pointer steps by one inside the sequence
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && row_ptr != seq_last) |=> (row_ptr == $past(row_ptr) + AW'(1)));
  // R5: position advances by the lane count, modulo the period
  p_base_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> (pos_base == $past(pos_base) + IDX_W'(LANES)));
  // R7: stopping rewinds pointer and position
  p_rewind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (row_ptr == '0 && pos_base == '0));
  // R2: two-stage valid tracking
  p_lat_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ##1 lane_vld);
  // R7: no fresh group two cycles after a stopped cycle
  p_idle_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ##1 !lane_vld);
endmodule

// File: tb/tpe_tx_engine_bench.sv
module tpe_tx_engine_bench;
  localparam int LANES = 8;
  localparam int TH_W  = 7;
  localparam int LB_W  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic [3:0]  seq_last = '0;
  logic        pat_we = 1'b0;
  logic [3:0]  pat_addr = '0;
  logic [63:0] pat_wdata = '0;
  logic        cor_we = 1'b0;
  logic [4:0]  cor_idx = '0;
  logic [7:0]  cor_wdata = '0;
  logic        lane_vld;
  logic [55:0] lane_therm;
  logic [39:0] lane_bin;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0]        rows [16][LANES];
  logic signed [7:0] corr [32];
  logic [55:0]       last_th;
  logic [39:0]       last_bn;

  tpe_tx_engine u_tpe_tx_engine (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .seq_last(seq_last),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .cor_we(cor_we), .cor_idx(cor_idx), .cor_wdata(cor_wdata),
    .lane_vld(lane_vld), .lane_therm(lane_therm), .lane_bin(lane_bin));

  always #10ns clk = ~clk;

  task automatic expect_group(int j, int len, output logic [55:0] th, output logic [39:0] bn);
    th = '0;
    bn = '0;
    for (int k = 0; k < LANES; k++) begin
      int s;
      int m;
      s = int'(rows[j % len][k]) + int'(corr[(8*j + k) % 32]);
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      m = s / 32;
      th[k*TH_W +: TH_W] = 7'((1 << m) - 1);
      bn[k*LB_W +: LB_W] = 5'(s % 32);
    end
  endtask

  task automatic check_out(string req, logic ev, logic [55:0] eth, logic [39:0] ebn);
    checks++;
    if (lane_vld !== ev || lane_therm !== eth || lane_bin !== ebn) begin
      bad++;
      $display("FAIL %s: actual vld=%0b therm=%h bin=%h expected vld=%0b therm=%h bin=%h",
               req, lane_vld, lane_therm, lane_bin, ev, eth, ebn);
    end
  endtask

  task automatic load_tables();
    for (int r = 0; r < 16; r++) begin
      @(posedge clk); #1ns;
      pat_we = 1'b1;
      pat_addr = 4'(r);
      for (int k = 0; k < LANES; k++) pat_wdata[k*8 +: 8] = rows[r][k];
    end
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #1ns;
      pat_we = 1'b0;
      cor_we = 1'b1;
      cor_idx = 5'(i);
      cor_wdata = corr[i];
    end
    @(posedge clk); #1ns;
    cor_we = 1'b0;
  endtask

  task automatic run_stream(int n, int len, string req);
    logic [55:0] eth;
    logic [39:0] ebn;
    @(posedge clk); #1ns;
    seq_last = 4'(len - 1);
    run_en = 1'b1;
    for (int cyc = 0; cyc <= n; cyc++) begin
      @(posedge clk);
      if (cyc == n - 1) begin #1ns; run_en = 1'b0; end
      @(negedge clk);
      if (cyc >= 1) begin
        expect_group(cyc - 1, len, eth, ebn);
        check_out(req, 1'b1, eth, ebn);
        last_th = eth;
        last_bn = ebn;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_out("R1 reset outputs", 1'b0, '0, '0);
  endtask

  task automatic t_plain();
    for (int r = 0; r < 16; r++)
      for (int k = 0; k < LANES; k++) rows[r][k] = 8'((r * 37 + k * 29 + 3) % 256);
    for (int i = 0; i < 32; i++) corr[i] = '0;
    load_tables();
    run_stream(6, 4, "R2 R4 R6 plain stream wrap");
  endtask

  task automatic t_single_row();
    run_stream(3, 1, "R6 single row loop");
  endtask

  task automatic t_corr();
    for (int i = 0; i < 32; i++) corr[i] = 8'(i * 7 - 100);
    for (int r = 0; r < 16; r++)
      for (int k = 0; k < LANES; k++) rows[r][k] = 8'(100 + ((r * 11 + k * 5) % 50));
    load_tables();
    run_stream(9, 5, "R5 position corrections");
  endtask

  task automatic t_clamp();
    for (int i = 0; i < 32; i++) corr[i] = (i % 2 == 0) ? 8'sd20 : -8'sd10;
    for (int k = 0; k < LANES; k++) begin
      rows[0][k] = (k < 4) ? 8'd250 : 8'd4;
      rows[1][k] = (k % 2 == 0) ? 8'd255 : 8'd9;
    end
    load_tables();
    run_stream(2, 2, "R3 clamp high and low");
  endtask

  task automatic t_idle();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check_out("R7 idle hold", 1'b0, last_th, last_bn);
    end
    run_stream(2, 3, "R7 restart at row 0");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;
    t_reset();
    t_plain();
    t_single_row();
    t_corr();
    t_clamp();
    t_idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule